// File: doc/BRIEF.md
# Clock-Enabled SPI Master with Early Word Request

This block is an SPI bus master that runs entirely on one fast system clock. Nothing in it uses a derived clock: a counter issues one enable pulse per half period of the serial clock, and every register on the serial side advances only on those pulses. The clock polarity and phase are taken from two mode inputs when a transfer begins, so all four SPI modes can be used from one instance.

The user loads a word with a one-cycle write strobe. While a word is being shifted, the block raises a one-cycle request a fixed number of cycles before it needs the next word. If a word is written in answer, it follows the current one with no gap in the serial clock and the select line stays low. If no word arrives, the select line rises half a serial period after the last clock edge.

The select line, the serial clock and MOSI pass through the same register pipeline, so they reach the pins in the same phase. MISO is captured by the receive shift logic without an input register. The capture strobe is delayed through a matching pipeline, so each bit is taken one cycle after the pin edge that samples it. Every received word is shown with a single-cycle valid pulse.

Top module: `spi_master_ce`

## Requirements
- R1: Reset outcome: after reset the select output is high, SCK equals the polarity input, and the word request and receive-valid outputs are low.
- R2: During a transfer, consecutive SCK edges at the pins are always CLK_DIV/2 system cycles apart. This includes the step from one word to the next in a continuous burst.
- R3: SCK rests at the polarity level while the select output is high. A polarity value of 1 means SCK rests high.
- R4: Words go out on MOSI most significant bit first. In phase 0, data is valid before the first edge and changes on trailing edges. In phase 1, data changes on leading edges. A leading edge is one that moves SCK away from its rest level. A slave that samples on the opposite edge receives the written word in all four modes.
- R5: MISO is sampled on leading edges in phase 0 and on trailing edges in phase 1, most significant bit first. Each completed word appears on the receive data output with the valid output high for exactly one cycle.
- R6: The select output falls exactly CLK_DIV cycles before the first SCK edge at the pins. It rises exactly CLK_DIV/2 cycles after the last edge.
- R7: The word request is high for one cycle per word. The last SCK edge of that word appears at the pins PREFETCH + 1 + LINE_DLY cycles later. PREFETCH must be at least 1.
- R8: A word written no later than the cycle in which the request is high is sent right after the current word. The select output stays low, and the burst has 2*DATA_W SCK edges per word.
- R9: When no word is written in answer to the request, the transfer ends after the current word: 2*DATA_W edges and a single rise of the select output.
- R10: The polarity and phase inputs are taken only when a transfer starts. Changing them during a transfer alters neither the SCK waveform nor the data in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpol_i | input | 1 | Clock polarity: SCK rest level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| tx_data_i | input | DATA_W | Word to transmit |
| tx_we_i | input | 1 | Write strobe for tx_data_i |
| tx_req_o | output | 1 | One-cycle request for the next word, issued PREFETCH cycles early |
| rx_data_o | output | DATA_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is updated |
| sck_o | output | 1 | Serial clock |
| ssel_n_o | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The main function is driven with a table of single-word transfers. The table covers all four polarity and phase combinations, with words whose bit patterns are not symmetric, so a reversed bit order, a swapped sampling edge or a wrong rest level each corrupts a different direction of data. Three-word bursts in modes 0 and 3 show whether word chaining keeps the select line low, keeps the SCK edge spacing constant, and places the request at the right cycle. A transfer whose mode inputs are flipped midway shows whether the mode is taken only at the start.

// File: rtl/spi_ce_pkg.sv
package spi_ce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TAIL,
    ST_GAP
  } seq_state_e;

  // Width of a counter that spans one half period.
  function automatic int half_cnt_w(input int half);
    return (half > 1) ? $clog2(half) : 1;
  endfunction

endpackage

// File: rtl/spi_ce_clkgen.sv
module spi_ce_clkgen
  import spi_ce_pkg::*;
#(
  parameter int HALF = 2,
  parameter int CW   = half_cnt_w(HALF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  output logic          tick_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_END);
  assign cnt_o  = cnt_q;

  // Counter is held at zero while idle, so the first half period is full.
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_ce_linedly.sv
module spi_ce_linedly #(
  parameter int               WIDTH   = 3,
  parameter int               DEPTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[g] <= RST_VAL;
        else     stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[g] <= RST_VAL;
        else     stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/spi_ce_seq.sv
module spi_ce_seq
  import spi_ce_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF     = 2,
  parameter int PREFETCH = 2,
  parameter int CW       = half_cnt_w(HALF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic [DW-1:0] di_i,
  input  logic          di_we_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  output logic          run_o,
  output logic          sel_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          samp_o,
  output logic          req_o
);

  localparam int              NE     = 2 * DW;
  localparam int              EW     = $clog2(NE);
  localparam int              RW     = $clog2(NE * HALF + 1);
  localparam logic [EW-1:0]   LAST_E = EW'(NE - 1);
  localparam logic [RW-1:0]   REQ_AT = RW'(PREFETCH + 1);

  if (PREFETCH < 1) begin : g_bad_prefetch
    $error("PREFETCH must be at least 1");
  end
  if (PREFETCH + 1 > NE * HALF - 1) begin : g_bad_lead
    $error("PREFETCH exceeds one word time");
  end

  seq_state_e    st_q;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] hold_q, tx_q;
  logic          pend_q, mosi_q, sck_q, sel_q, cpol_q, cpha_q, samp_q, req_q;

  logic          lead_e, last_e, xtick, ld_cpha, load, chg;
  logic [RW-1:0] rem;

  always_comb begin
    lead_e  = ~edge_q[0];
    last_e  = (edge_q == LAST_E);
    xtick   = (st_q == ST_XFER) && tick_i;
    ld_cpha = (st_q == ST_IDLE) ? cpha_i : cpha_q;
    load    = ((st_q == ST_IDLE) && pend_q) || (xtick && last_e && pend_q);
    chg     = xtick && (cpha_q ? lead_e : (!lead_e && !last_e));
    rem     = RW'(LAST_E - edge_q) * RW'(HALF) + RW'(HALF - 1) - RW'(cnt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      hold_q <= '0;
      tx_q   <= '0;
      pend_q <= 1'b0;
      mosi_q <= 1'b0;
      sck_q  <= 1'b0;
      sel_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      samp_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      samp_q <= xtick && (lead_e ^ cpha_q);
      req_q  <= (st_q == ST_XFER) && (rem == REQ_AT);
      pend_q <= di_we_i | (pend_q & ~load);
      if (di_we_i) hold_q <= di_i;

      if (load) begin
        tx_q <= ld_cpha ? hold_q : (hold_q << 1);
        if (!ld_cpha) mosi_q <= hold_q[DW-1];
      end else if (chg) begin
        mosi_q <= tx_q[DW-1];
        tx_q   <= tx_q << 1;
      end

      case (st_q)
        ST_IDLE: begin
          sck_q <= cpol_i;
          if (pend_q) begin
            cpol_q <= cpol_i;
            cpha_q <= cpha_i;
            sel_q  <= 1'b1;
            edge_q <= '0;
            st_q   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick_i) st_q <= ST_XFER;
        end
        ST_XFER: begin
          if (tick_i) begin
            sck_q <= ~sck_q;
            if (last_e) begin
              edge_q <= '0;
              if (!pend_q) st_q <= ST_TAIL;
            end else begin
              edge_q <= edge_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick_i) begin
            sel_q <= 1'b0;
            st_q  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q != ST_IDLE);
  assign sel_o  = sel_q;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign samp_o = samp_q;
  assign req_o  = req_q;

  AST_SCK_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && !tick_i) |=> $stable(sck_q)); // R2
  AST_SEL_HELD_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER) |=> sel_q); // R8
  AST_TAIL_REST_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TAIL) |-> (sck_q == cpol_q)); // R3
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q); // R7

endmodule

// File: rtl/spi_ce_rx.sv
module spi_ce_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_i,
  input  logic          miso_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);

  localparam int            BW    = $clog2(DW);
  localparam logic [BW-1:0] B_END = BW'(DW - 1);

  logic [DW-1:0] sr_q, nxt;
  logic [BW-1:0] bit_q;
  logic          valid_q;

  assign nxt = {sr_q[DW-2:0], miso_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      bit_q   <= '0;
      data_o  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= samp_i && (bit_q == B_END);
      if (samp_i) begin
        sr_q <= nxt;
        if (bit_q == B_END) begin
          bit_q  <= '0;
          data_o <= nxt;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R5

endmodule

// File: rtl/spi_master_ce.sv
module spi_master_ce
  import spi_ce_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CLK_DIV  = 4,
  parameter int PREFETCH = 2,
  parameter int LINE_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  output logic              tx_req_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sck_o,
  output logic              ssel_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = half_cnt_w(HALF);

  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
    $error("CLK_DIV must be even and at least 2");
  end
  if (LINE_DLY < 1 || DATA_W < 2) begin : g_bad_cfg
    $error("LINE_DLY must be at least 1 and DATA_W at least 2");
  end

  logic          run, tick, sel, sck_int, mosi_int, samp, samp_d;
  logic [CW-1:0] cnt;
  logic [2:0]    line_d, line_q;

  spi_ce_clkgen #(.HALF(HALF), .CW(CW)) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .tick_o (tick),
    .cnt_o  (cnt)
  );

  spi_ce_seq #(.DW(DATA_W), .HALF(HALF), .PREFETCH(PREFETCH), .CW(CW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .di_i    (tx_data_i),
    .di_we_i (tx_we_i),
    .tick_i  (tick),
    .cnt_i   (cnt),
    .run_o   (run),
    .sel_o   (sel),
    .sck_o   (sck_int),
    .mosi_o  (mosi_int),
    .samp_o  (samp),
    .req_o   (tx_req_o)
  );

  // Select, clock and data share one pipeline so their phase is kept.
  assign line_d = {~sel, sck_int, mosi_int};

  spi_ce_linedly #(.WIDTH(3), .DEPTH(LINE_DLY), .RST_VAL(3'b100)) u_line (
    .clk (clk),
    .rst (rst),
    .d_i (line_d),
    .q_o (line_q)
  );

  // Capture strobe follows the pin timing of the sampling edge.
  spi_ce_linedly #(.WIDTH(1), .DEPTH(LINE_DLY), .RST_VAL(1'b0)) u_samp (
    .clk (clk),
    .rst (rst),
    .d_i (samp),
    .q_o (samp_d)
  );

  spi_ce_rx #(.DW(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .samp_i  (samp_d),
    .miso_i  (miso_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

  assign ssel_n_o = line_q[2];
  assign sck_o    = line_q[1];
  assign mosi_o   = line_q[0];

  AST_REQ_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> run); // R7

endmodule

// File: tb/spi_master_ce_tb.sv
`timescale 1ns/1ps
module spi_master_ce_tb;

  localparam int DW   = 8;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int PF   = 2;
  localparam int LD   = 2;
  localparam int NE   = 2 * DW;

  // {cpol, cpha, word sent by master, word returned by slave}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h96, 8'hE1},
    {1'b1, 1'b0, 8'h1F, 8'hC8},
    {1'b1, 1'b1, 8'hD2, 8'h47},
    {1'b0, 1'b0, 8'h01, 8'h80},
    {1'b0, 1'b1, 8'h80, 8'h01},
    {1'b1, 1'b0, 8'hFE, 8'h7F},
    {1'b1, 1'b1, 8'h6B, 8'hB6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpol_i = 1'b0, cpha_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic tx_we_i = 1'b0;
  logic miso_i = 1'b0;
  logic tx_req_o, rx_valid_o, sck_o, ssel_n_o, mosi_o;
  logic [DW-1:0] rx_data_o;

  always #2 clk = ~clk;

  spi_master_ce #(.DATA_W(DW), .CLK_DIV(DIV), .PREFETCH(PF), .LINE_DLY(LD)) u_dut (
    .clk (clk), .rst (rst), .cpol_i (cpol_i), .cpha_i (cpha_i),
    .tx_data_i (tx_data_i), .tx_we_i (tx_we_i), .tx_req_o (tx_req_o),
    .rx_data_o (rx_data_o), .rx_valid_o (rx_valid_o), .sck_o (sck_o),
    .ssel_n_o (ssel_n_o), .mosi_o (mosi_o), .miso_i (miso_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // slave model and scoreboard
  logic cpol_m = 1'b0, cpha_m = 1'b0;
  logic [DW-1:0] sl_tx [4];
  logic [DW-1:0] sl_got [4];
  logic [DW-1:0] dv_words [4];
  logic [DW-1:0] sl_sr = '0;
  int sl_bit = 0, sl_rbits = 0;
  logic p_sck = 1'b0, p_ssel = 1'b1;
  int fall_cyc = 0, last_edge = 0, burst_edges = 0, ssel_rises = 0;
  int req_cyc = 0, req_cnt = 0, req_target = 0, dv_cnt = 0;
  bit req_wait = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic sl_bitval(input int i);
    if (i / DW < 4) return sl_tx[i / DW][DW - 1 - (i % DW)];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      p_sck  = sck_o;
      p_ssel = ssel_n_o;
    end else begin
      cyc++;
      if (p_ssel && !ssel_n_o) begin
        fall_cyc = cyc; burst_edges = 0; sl_bit = 0; sl_rbits = 0;
        if (!cpha_m) begin miso_i <= sl_bitval(0); sl_bit = 1; end
      end
      if (!ssel_n_o && sck_o != p_sck) begin
        burst_edges++;
        if (burst_edges == 1) chk(cyc - fall_cyc == DIV, "R6 lead", cyc - fall_cyc, DIV);
        else chk(cyc - last_edge == HALF, "R2 edge spacing", cyc - last_edge, HALF);
        last_edge = cyc;
        if ((sck_o != cpol_m) ^ cpha_m) begin
          sl_sr = {sl_sr[DW-2:0], mosi_o};
          sl_rbits++;
          if (sl_rbits % DW == 0 && sl_rbits / DW <= 4) sl_got[sl_rbits / DW - 1] = sl_sr;
        end else begin
          miso_i <= sl_bitval(sl_bit);
          sl_bit++;
        end
        if (req_wait && burst_edges == req_target) begin
          chk(cyc - req_cyc == PF + 1 + LD, "R7 request lead", cyc - req_cyc, PF + 1 + LD);
          req_wait = 0;
        end
      end
      if (!p_ssel && ssel_n_o) begin
        ssel_rises++;
        chk(cyc - last_edge == HALF, "R6 tail", cyc - last_edge, HALF);
      end
      if (tx_req_o) begin
        req_cnt++; req_cyc = cyc; req_wait = 1;
        req_target = (burst_edges / NE + 1) * NE;
      end
      if (rx_valid_o) begin
        if (dv_cnt < 4) dv_words[dv_cnt] = rx_data_o;
        dv_cnt++;
      end
      p_sck  = sck_o;
      p_ssel = ssel_n_o;
      if (cyc > 150000 && !done) begin
        done = 1;
        chk(0, "watchdog", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol_i = pol; cpha_i = pha; cpol_m = pol; cpha_m = pha;
    wait_cyc(8);
  endtask

  task automatic clear_sb();
    dv_cnt = 0; ssel_rises = 0; req_cnt = 0; req_wait = 0;
    for (int k = 0; k < 4; k++) begin
      sl_got[k] = '0; dv_words[k] = '0; sl_tx[k] = '0;
    end
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge clk);
    tx_data_i = d; tx_we_i = 1'b1;
    @(negedge clk);
    tx_we_i = 1'b0;
  endtask

  task automatic wait_sel(input logic lvl);
    int g = 0;
    while (ssel_n_o !== lvl && g < 3000) begin @(negedge clk); g++; end
    if (g >= 3000) chk(0, "watchdog select", int'(ssel_n_o), int'(lvl));
  endtask

  task automatic wait_done();
    wait_sel(1'b0);
    wait_sel(1'b1);
    wait_cyc(6);
  endtask

  // Writes n words, each further word in the cycle its request is high.
  task automatic stream(input int n, input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                        input logic [DW-1:0] w2);
    logic [DW-1:0] ws [3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    write_word(ws[0]);
    for (int k = 1; k < n; k++) begin
      int g = 0;
      while (!tx_req_o && g < 3000) begin @(negedge clk); g++; end
      tx_data_i = ws[k]; tx_we_i = 1'b1;
      @(negedge clk);
      tx_we_i = 1'b0;
    end
  endtask

  task automatic burst_test(input logic pol, input logic pha);
    set_mode(pol, pha);
    clear_sb();
    sl_tx[0] = 8'h18; sl_tx[1] = 8'hE7; sl_tx[2] = 8'h5A;
    stream(3, 8'h81, 8'h7E, 8'hC3);
    wait_done();
    chk(ssel_rises == 1, "R8 select held over burst", ssel_rises, 1);
    chk(burst_edges == 3 * NE, "R8 burst edges", burst_edges, 3 * NE);
    chk(dv_cnt == 3, "R5 burst valid count", dv_cnt, 3);
    chk(dv_words[0] == 8'h18 && dv_words[1] == 8'hE7 && dv_words[2] == 8'h5A,
        "R5 burst rx words", {8'h0, dv_words[0], dv_words[1], dv_words[2]}, 32'h18E75A);
    chk(sl_got[0] == 8'h81 && sl_got[1] == 8'h7E && sl_got[2] == 8'hC3,
        "R4 burst mosi words", {8'h0, sl_got[0], sl_got[1], sl_got[2]}, 32'h817EC3);
  endtask

  initial begin
    clear_sb();
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    // R1 reset outcome
    chk(ssel_n_o == 1'b1, "R1 select high", int'(ssel_n_o), 1);
    chk(sck_o == 1'b0, "R1 sck at polarity", int'(sck_o), 0);
    chk(tx_req_o == 1'b0 && rx_valid_o == 1'b0, "R1 strobes low",
        int'({tx_req_o, rx_valid_o}), 0);

    // R3 rest level follows polarity while deselected
    set_mode(1'b1, 1'b0);
    chk(sck_o == 1'b1, "R3 rest level high", int'(sck_o), 1);

    // table of single-word transfers, no answer to the request (R9)
    for (int i = 0; i < 8; i++) begin
      logic [17:0] v;
      v = VEC[i];
      set_mode(v[17], v[16]);
      clear_sb();
      sl_tx[0] = v[7:0];
      write_word(v[15:8]);
      wait_done();
      chk(sl_got[0] == v[15:8], "R4 mosi word", int'(sl_got[0]), int'(v[15:8]));
      chk(dv_cnt == 1, "R5 one valid pulse", dv_cnt, 1);
      chk(dv_words[0] == v[7:0], "R5 rx word", int'(dv_words[0]), int'(v[7:0]));
      chk(burst_edges == NE && ssel_rises == 1 && req_cnt == 1, "R9 single word end",
          burst_edges, NE);
      chk(sck_o == v[17], "R3 rest level after word", int'(sck_o), int'(v[17]));
    end

    // continuous bursts (R8, R2, R7 via monitor)
    burst_test(1'b0, 1'b0);
    burst_test(1'b1, 1'b1);

    // R10 mode inputs flipped mid-transfer are ignored
    set_mode(1'b0, 1'b1);
    clear_sb();
    sl_tx[0] = 8'h4D;
    write_word(8'hB2);
    wait_sel(1'b0);
    cpol_i = 1'b1; cpha_i = 1'b0;
    wait_sel(1'b1);
    wait_cyc(6);
    chk(sl_got[0] == 8'hB2, "R10 mosi after mode flip", int'(sl_got[0]), 8'hB2);
    chk(dv_words[0] == 8'h4D, "R10 rx after mode flip", int'(dv_words[0]), 8'h4D);
    chk(burst_edges == NE, "R10 edge count after mode flip", burst_edges, NE);
    chk(sck_o == 1'b1, "R3 rest level takes new polarity", int'(sck_o), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule